// File: doc/BRIEF.md
# Tape Controller Command Sequencer

This block sequences commands for a magnetic tape controller serving up to eight drive units. A start request names one unit. The sequencer waits until that unit has finished any rewind in progress. It then requests an 8-bit command from the channel and looks the opcode up in an attribute table. The table marks whether the command needs an attached drive, needs write enable, moves tape in reverse, or involves no tape motion at all.

Depending on the command and the unit's condition, one of two things happens:
- The command ends at once, with a normal or an unusual end.
- The command is handed to the drive side as a one-cycle start strobe. The drive side reports back with a done pulse and a 2-bit result.

After a normal end, the channel's chain flag decides whether the next command is fetched or the block goes idle. A per-unit status byte combines stored error and event bits with the live drive condition. Only one unit sequence runs at a time.

Top module: `tape_cmd_seq`

## Requirements
- R1: A command with bit 7 set, or whose attribute entry is empty (for example 0x00), ends with a normal end, with no start strobe and no change to the status byte.
- R2: A valid command that passes its checks raises `op_start_o` for exactly one cycle, with `op_code_o` and `op_unit_o` showing the command and the unit. A done pulse with result 0 then gives a normal end.
- R3: A reverse command (0x0C, 0x4B, 0x5B) issued while the unit's BOT input is high ends at once with an unusual end. There is no start strobe, and the stored status bits are left as they were.
- R4: A command with tape motion clears the unit's stored status bits (write-lock error, end of file, data error) before it executes. The no-motion commands 0x03, 0x04 and 0x63 leave those bits unchanged.
- R5: Write (0x01) or write-tapemark (0x73) on a write-protected unit sets status bit 5 (write-lock error) and ends with an unusual end, with no start strobe.
- R6: While the started unit's rewinding input is high, no command is requested. The request is raised once rewinding drops.
- R7: After a normal end with `chain_i` high, `cmd_req_o` is asserted in the same cycle as `end_o`. An unusual end, or a normal end without chaining, returns the block to idle.
- R8: Status byte for the selected unit: bit 7 = 0, bit 6 = attached and not protected, bit 5 = write-lock error, bit 4 = end of file, bit 3 = data error, bit 2 = BOT input, bit 1 = 0, bit 0 = rewinding input. After reset all stored bits are 0.
- R9: `halt_i` in any active state produces `end_o` with `end_unusual_o`, and drops `busy_o` on the next clock.
- R10: `busy_o` is high from the accepted start until the block returns to idle. A start request while busy is ignored.
- R11: A command that needs an attached drive waits, without a start strobe, while the unit is not attached. It proceeds once the unit becomes attached.
- R12: An operation result of 1 (tapemark) sets status bit 4, and a result of 2 (data error) sets status bit 3; both give an unusual end. A successful write-tapemark also sets bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request |
| start_unit_i | input | 3 | Unit named by the start request |
| halt_i | input | 1 | Halt the active sequence |
| cmd_valid_i | input | 1 | Command byte valid from channel |
| cmd_byte_i | input | 8 | Command byte |
| chain_i | input | 1 | Channel requests command chaining |
| attached_i | input | 8 | Per-unit drive attached |
| wprot_i | input | 8 | Per-unit write protected |
| bot_i | input | 8 | Per-unit at load point |
| rewinding_i | input | 8 | Per-unit rewind in progress |
| op_done_i | input | 1 | Drive side finished the operation |
| op_result_i | input | 2 | 0 ok, 1 tapemark, 2 data error |
| status_sel_i | input | 3 | Unit whose status byte is shown |
| cmd_req_o | output | 1 | Command fetch request to channel |
| op_start_o | output | 1 | One-cycle operation start strobe |
| op_code_o | output | 8 | Command being executed |
| op_unit_o | output | 3 | Unit being served |
| end_o | output | 1 | Channel end strobe |
| end_unusual_o | output | 1 | End is unusual (with `end_o`) |
| busy_o | output | 1 | A unit sequence is active |
| status_o | output | 8 | Status byte of the selected unit |

## Verification
The hardest situation to reach from the ports is a command chain that continues from a normal end while the same unit's stored status must survive or be cleared, depending on the motion attribute of each link.

The bench holds `chain_i` high across an end, then feeds the next command as soon as `cmd_req_o` returns, in the same cycle as the end strobe. It also holds a sequence parked in the attach-wait and rewind-hold states for several cycles before releasing it. Finally, it injects a halt both during command fetch and during an executing operation.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;

    localparam int CMD_W = 8;

    // status byte bit positions
    localparam int ST_OVR = 7;
    localparam int ST_WEN = 6;
    localparam int ST_WLE = 5;
    localparam int ST_EOF = 4;
    localparam int ST_DTE = 3;
    localparam int ST_BOT = 2;
    localparam int ST_EOT = 1;
    localparam int ST_REW = 0;

    localparam logic [CMD_W-1:0] OPC_WRITE_MARK = 8'h73;

    typedef struct packed {
        logic no_motion;
        logic reverse;
        logic need_wen;
        logic need_att;
    } cmd_attr_t;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_HOLD  = 3'd1,
        SQ_FETCH = 3'd2,
        SQ_CHECK = 3'd3,
        SQ_EXEC  = 3'd4
    } seq_state_t;

    typedef enum logic [1:0] {
        RES_OK   = 2'd0,
        RES_MARK = 2'd1,
        RES_DERR = 2'd2
    } op_result_t;

    function automatic cmd_attr_t attr_of(input logic [CMD_W-1:0] c);
        cmd_attr_t a;
        a = '0;
        if (!c[7]) begin
            case (c)
                8'h01, 8'h73:                      a = '{no_motion: 1'b0, reverse: 1'b0, need_wen: 1'b1, need_att: 1'b1};
                8'h02, 8'h13, 8'h23, 8'h33,
                8'h43, 8'h53:                      a = '{no_motion: 1'b0, reverse: 1'b0, need_wen: 1'b0, need_att: 1'b1};
                8'h0C, 8'h4B, 8'h5B:               a = '{no_motion: 1'b0, reverse: 1'b1, need_wen: 1'b0, need_att: 1'b1};
                8'h03, 8'h04, 8'h63:               a = '{no_motion: 1'b1, reverse: 1'b0, need_wen: 1'b0, need_att: 1'b0};
                default:                           a = '0;
            endcase
        end
        return a;
    endfunction

endpackage

// File: rtl/tape_cmd_decode.sv
module tape_cmd_decode
    import tape_seq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    output cmd_attr_t        attr_o,
    output logic             valid_o
);
    always_comb begin
        attr_o  = attr_of(cmd_i);
        valid_o = (attr_o != '0);
    end
endmodule

// File: rtl/tape_unit_status.sv
module tape_unit_status #(
    parameter int NUM_UNITS = 8,
    localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [UNIT_W-1:0] wr_idx_i,
    input  logic              clr_i,
    input  logic              set_wle_i,
    input  logic              set_eof_i,
    input  logic              set_dte_i,
    input  logic [UNIT_W-1:0] rd_idx_i,
    output logic [2:0]        rd_bits_o   // {wle, eof, dte}
);
    logic [2:0] bits_q [NUM_UNITS];

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        logic hit;
        assign hit = (wr_idx_i == UNIT_W'(u));
        always_ff @(posedge clk) begin
            if (rst) begin
                bits_q[u] <= '0;
            end else if (hit) begin
                // sets take priority over the clear issued in the same cycle
                bits_q[u][2] <= set_wle_i | (bits_q[u][2] & ~clr_i);
                bits_q[u][1] <= set_eof_i | (bits_q[u][1] & ~clr_i);
                bits_q[u][0] <= set_dte_i | (bits_q[u][0] & ~clr_i);
            end
        end
    end

    assign rd_bits_o = bits_q[rd_idx_i];
endmodule

// File: rtl/tape_cmd_seq.sv
module tape_cmd_seq
    import tape_seq_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [UNIT_W-1:0]    start_unit_i,
    input  logic                 halt_i,
    input  logic                 cmd_valid_i,
    input  logic [7:0]           cmd_byte_i,
    input  logic                 chain_i,
    input  logic [NUM_UNITS-1:0] attached_i,
    input  logic [NUM_UNITS-1:0] wprot_i,
    input  logic [NUM_UNITS-1:0] bot_i,
    input  logic [NUM_UNITS-1:0] rewinding_i,
    input  logic                 op_done_i,
    input  logic [1:0]           op_result_i,
    input  logic [UNIT_W-1:0]    status_sel_i,
    output logic                 cmd_req_o,
    output logic                 op_start_o,
    output logic [7:0]           op_code_o,
    output logic [UNIT_W-1:0]    op_unit_o,
    output logic                 end_o,
    output logic                 end_unusual_o,
    output logic                 busy_o,
    output logic [7:0]           status_o
);
    seq_state_t        state_q, state_d;
    logic [UNIT_W-1:0] unit_q;
    logic [CMD_W-1:0]  cmd_q;
    logic              op_start_q, end_q, unus_q;

    cmd_attr_t attr;
    logic      cmd_ok;

    tape_cmd_decode u_dec (
        .cmd_i  (cmd_q),
        .attr_o (attr),
        .valid_o(cmd_ok)
    );

    logic att_u, wp_u, bot_u, rew_u;
    assign att_u = attached_i[unit_q];
    assign wp_u  = wprot_i[unit_q];
    assign bot_u = bot_i[unit_q];
    assign rew_u = rewinding_i[unit_q];

    logic halting, in_check, in_exec;
    logic rev_block, att_wait, wlock;
    logic fin, fin_unus, go_exec;
    op_result_t res;

    assign res      = op_result_t'(op_result_i);
    assign halting  = halt_i && (state_q != SQ_IDLE);
    assign in_check = (state_q == SQ_CHECK) && !halt_i;
    assign in_exec  = (state_q == SQ_EXEC) && !halt_i;

    assign rev_block = cmd_ok && attr.reverse && bot_u;
    assign att_wait  = cmd_ok && !rev_block && attr.need_att && !att_u;
    assign wlock     = cmd_ok && !rev_block && !att_wait && attr.need_wen && wp_u;

    always_comb begin
        state_d  = state_q;
        fin      = 1'b0;
        fin_unus = 1'b0;
        go_exec  = 1'b0;
        unique case (state_q)
            SQ_IDLE:  if (start_i) state_d = SQ_HOLD;
            SQ_HOLD:  if (!rew_u) state_d = SQ_FETCH;
            SQ_FETCH: if (cmd_valid_i) state_d = SQ_CHECK;
            SQ_CHECK: begin
                if (!cmd_ok) begin
                    fin = 1'b1;
                end else if (rev_block || wlock) begin
                    fin      = 1'b1;
                    fin_unus = 1'b1;
                end else if (!att_wait) begin
                    go_exec = 1'b1;
                    state_d = SQ_EXEC;
                end
            end
            SQ_EXEC: begin
                if (op_done_i) begin
                    fin      = 1'b1;
                    fin_unus = (res != RES_OK);
                end
            end
            default: state_d = SQ_IDLE;
        endcase
        if (fin) state_d = (!fin_unus && chain_i) ? SQ_FETCH : SQ_IDLE;
        if (halting) begin
            state_d  = SQ_IDLE;
            fin      = 1'b1;
            fin_unus = 1'b1;
            go_exec  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            unit_q     <= '0;
            cmd_q      <= '0;
            op_start_q <= 1'b0;
            end_q      <= 1'b0;
            unus_q     <= 1'b0;
        end else begin
            state_q    <= state_d;
            op_start_q <= go_exec;
            end_q      <= fin;
            unus_q     <= fin_unus;
            if (state_q == SQ_IDLE && start_i) unit_q <= start_unit_i;
            if (state_q == SQ_FETCH && cmd_valid_i && !halt_i) cmd_q <= cmd_byte_i;
        end
    end

    // status bookkeeping for the served unit
    logic       st_clr, st_wle, st_eof, st_dte;
    logic [2:0] stored;

    assign st_clr = in_check && cmd_ok && !rev_block && !attr.no_motion;
    assign st_wle = in_check && wlock;
    assign st_eof = in_exec && op_done_i &&
                    (res == RES_MARK || (res == RES_OK && cmd_q == OPC_WRITE_MARK));
    assign st_dte = in_exec && op_done_i && (res == RES_DERR);

    tape_unit_status #(.NUM_UNITS(NUM_UNITS)) u_status (
        .clk      (clk),
        .rst      (rst),
        .wr_idx_i (unit_q),
        .clr_i    (st_clr),
        .set_wle_i(st_wle),
        .set_eof_i(st_eof),
        .set_dte_i(st_dte),
        .rd_idx_i (status_sel_i),
        .rd_bits_o(stored)
    );

    always_comb begin
        status_o         = '0;
        status_o[ST_WEN] = attached_i[status_sel_i] & ~wprot_i[status_sel_i];
        status_o[ST_WLE] = stored[2];
        status_o[ST_EOF] = stored[1];
        status_o[ST_DTE] = stored[0];
        status_o[ST_BOT] = bot_i[status_sel_i];
        status_o[ST_REW] = rewinding_i[status_sel_i];
    end

    assign cmd_req_o     = (state_q == SQ_FETCH);
    assign op_start_o    = op_start_q;
    assign op_code_o     = cmd_q;
    assign op_unit_o     = unit_q;
    assign end_o         = end_q;
    assign end_unusual_o = unus_q;
    assign busy_o        = (state_q != SQ_IDLE);
endmodule

// File: rtl/tape_cmd_seq_chk.sv
module tape_cmd_seq_chk #(
    parameter int NUM_UNITS = 8,
    localparam int UNIT_W   = $clog2(NUM_UNITS)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 start_i,
    input logic [UNIT_W-1:0]    start_unit_i,
    input logic                 halt_i,
    input logic [NUM_UNITS-1:0] wprot_i,
    input logic [NUM_UNITS-1:0] rewinding_i,
    input logic                 cmd_req_o,
    input logic                 op_start_o,
    input logic [7:0]           op_code_o,
    input logic [UNIT_W-1:0]    op_unit_o,
    input logic                 end_o,
    input logic                 end_unusual_o,
    input logic                 busy_o
);
    a_r9_halt_ends: assert property (@(posedge clk) disable iff (rst)
        (busy_o && halt_i) |=> (end_o && end_unusual_o && !busy_o));

    a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
        op_start_o |=> !op_start_o);

    a_r7_unusual_idles: assert property (@(posedge clk) disable iff (rst)
        (end_o && end_unusual_o) |-> !busy_o);

    a_r6_rewind_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i && rewinding_i[start_unit_i]) |=> !cmd_req_o);

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(op_unit_o));

    a_r5_no_protected_write: assert property (@(posedge clk) disable iff (rst)
        op_start_o |-> !(wprot_i[op_unit_o] && (op_code_o == 8'h01 || op_code_o == 8'h73)));
endmodule

bind tape_cmd_seq tape_cmd_seq_chk #(.NUM_UNITS(NUM_UNITS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .start_unit_i (start_unit_i),
    .halt_i       (halt_i),
    .wprot_i      (wprot_i),
    .rewinding_i  (rewinding_i),
    .cmd_req_o    (cmd_req_o),
    .op_start_o   (op_start_o),
    .op_code_o    (op_code_o),
    .op_unit_o    (op_unit_o),
    .end_o        (end_o),
    .end_unusual_o(end_unusual_o),
    .busy_o       (busy_o)
);

// File: tb/tape_cmd_seq_tb.sv
module tape_cmd_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NU = 8;

    logic       clk = 0, rst = 1;
    logic       start_i = 0, halt_i = 0, cmd_valid_i = 0, chain_i = 0, op_done_i = 0;
    logic [2:0] start_unit_i = 0, status_sel_i = 0;
    logic [7:0] cmd_byte_i = 0;
    logic [NU-1:0] attached_i = 0, wprot_i = 0, bot_i = 0, rewinding_i = 0;
    logic [1:0] op_result_i = 0;
    logic       cmd_req_o, op_start_o, end_o, end_unusual_o, busy_o;
    logic [7:0] op_code_o, status_o;
    logic [2:0] op_unit_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_cmd_seq u_dut (.*);

    int n_chk = 0, n_fail = 0;
    logic got_start, got_end, got_unus;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic start_seq(input int u);
        start_i = 1; start_unit_i = 3'(u);
        @(negedge clk);
        start_i = 0;
    endtask

    task automatic give_cmd(input logic [7:0] c);
        for (int k = 0; k < 50; k++) begin
            if (cmd_req_o) break;
            @(negedge clk);
        end
        cmd_valid_i = 1; cmd_byte_i = c;
        @(negedge clk);
        cmd_valid_i = 0;
    endtask

    task automatic finish_op(input logic [1:0] res);
        got_start = 0; got_end = 0; got_unus = 0;
        for (int k = 0; k < 50 && !got_end; k++) begin
            if (end_o) begin
                got_end = 1; got_unus = end_unusual_o;
            end else begin
                if (op_start_o) begin
                    got_start = 1; op_done_i = 1; op_result_i = res;
                end else op_done_i = 0;
                @(negedge clk);
            end
        end
        op_done_i = 0;
    endtask

    typedef struct packed {
        logic [2:0] unit;
        logic [7:0] cmd;
        logic       att, wp, bot;
        logic [1:0] res;
        logic       e_start, e_unus;
        logic [7:0] e_stat;
    } vec_t;

    localparam vec_t VEC [12] = '{
        '{3'd0, 8'h02, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 8'h44},
        '{3'd0, 8'h73, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h50},
        '{3'd0, 8'h04, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h50},
        '{3'd0, 8'h43, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h40},
        '{3'd0, 8'h02, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 8'h48},
        '{3'd1, 8'h01, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b1, 8'h20},
        '{3'd1, 8'h0C, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 8'h24},
        '{3'd1, 8'h85, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h24},
        '{3'd1, 8'h00, 1'b1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 8'h24},
        '{3'd2, 8'h4B, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h40},
        '{3'd2, 8'h33, 1'b1, 1'b0, 1'b0, 2'd1, 1'b1, 1'b1, 8'h50},
        '{3'd2, 8'h63, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 8'h50}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R2";
            1, 4, 10: return "R12";
            2, 3, 11: return "R4";
            5: return "R5";
            6: return "R3";
            7, 8: return "R1";
            default: return "R3";
        endcase
    endfunction

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state (R8, R10)
        chk("R10 reset busy", busy_o, 0);
        chk("R10 reset cmd_req", cmd_req_o, 0);
        chk("R9 reset end", end_o, 0);
        chk("R8 reset status", status_o, 0);

        // vector table walk
        for (int i = 0; i < 12; i++) begin
            attached_i[VEC[i].unit] = VEC[i].att;
            wprot_i[VEC[i].unit]    = VEC[i].wp;
            bot_i[VEC[i].unit]      = VEC[i].bot;
            start_seq(VEC[i].unit);
            give_cmd(VEC[i].cmd);
            finish_op(VEC[i].res);
            chk({vec_tag(i), " end seen"}, got_end, 1);
            chk({vec_tag(i), " start strobe"}, got_start, VEC[i].e_start);
            chk({vec_tag(i), " unusual"}, got_unus, VEC[i].e_unus);
            status_sel_i = VEC[i].unit;
            #1;
            chk({vec_tag(i), " R8 status"}, status_o, VEC[i].e_stat);
            @(negedge clk);
        end

        // R7 chaining after normal end
        chain_i = 1;
        start_seq(0);
        give_cmd(8'h03);
        finish_op(2'd0);
        chk("R7 chain normal end", got_unus, 0);
        chk("R7 chain refetch", cmd_req_o, 1);
        chain_i = 0;
        give_cmd(8'h80);
        finish_op(2'd0);
        chk("R1 chained invalid normal", got_unus, 0);
        @(negedge clk);
        chk("R7 idle without chain", busy_o, 0);
        // R7 unusual end does not chain
        chain_i = 1;
        start_seq(1);
        give_cmd(8'h01);
        finish_op(2'd0);
        chk("R7 unusual end", got_unus, 1);
        chk("R7 unusual no chain", busy_o, 0);
        chain_i = 0;
        @(negedge clk);

        // R2 / R10 start while busy ignored
        start_seq(0);
        give_cmd(8'h02);
        for (int k = 0; k < 20; k++) begin
            if (op_start_o) break;
            @(negedge clk);
        end
        chk("R2 op_start", op_start_o, 1);
        chk("R2 op_unit", op_unit_o, 0);
        chk("R2 op_code", op_code_o, 8'h02);
        start_i = 1; start_unit_i = 3'd4; op_done_i = 1; op_result_i = 2'd0;
        @(negedge clk);
        start_i = 0; op_done_i = 0;
        chk("R2 normal end", end_o, 1);
        chk("R2 not unusual", end_unusual_o, 0);
        @(negedge clk);
        chk("R10 start while busy ignored", busy_o, 0);

        // R9 halt during execution
        start_seq(2);
        give_cmd(8'h02);
        for (int k = 0; k < 20; k++) begin
            if (op_start_o) break;
            @(negedge clk);
        end
        halt_i = 1;
        @(negedge clk);
        halt_i = 0;
        chk("R9 halt end", end_o, 1);
        chk("R9 halt unusual", end_unusual_o, 1);
        chk("R9 halt idle", busy_o, 0);

        // R11 wait for attach
        attached_i[5] = 0;
        start_seq(5);
        give_cmd(8'h43);
        got_start = 0;
        for (int k = 0; k < 5; k++) begin
            if (op_start_o) got_start = 1;
            @(negedge clk);
        end
        chk("R11 no start unattached", got_start, 0);
        chk("R11 still busy", busy_o, 1);
        attached_i[5] = 1;
        finish_op(2'd0);
        chk("R11 start after attach", got_start, 1);
        chk("R11 normal end", got_unus, 0);
        @(negedge clk);

        // R6 rewind hold, then R9 halt during fetch
        rewinding_i[3] = 1;
        start_seq(3);
        repeat (5) @(negedge clk);
        chk("R6 no request while rewinding", cmd_req_o, 0);
        chk("R10 busy during hold", busy_o, 1);
        status_sel_i = 3'd3;
        #1;
        chk("R8 rewinding bit", status_o[0], 1);
        rewinding_i[3] = 0;
        @(negedge clk);
        chk("R6 request after rewind", cmd_req_o, 1);
        halt_i = 1;
        @(negedge clk);
        halt_i = 0;
        chk("R9 halt in fetch end", end_o & end_unusual_o, 1);
        chk("R9 halt in fetch idle", busy_o, 0);

        report();
    end
endmodule